// File: doc/BRIEF.md
# Dual-Mode FIFO With Status Flags

A single-clock first-in first-out buffer of depth D = 2^AW words. It has two read disciplines, and the one in use is captured from a configuration pin while master reset is held. In standard mode every word, the first one included, is moved to the output register by an explicit read request. In fall-through mode the oldest stored word is moved to the output register without any request, and a read request consumes it. The output register therefore holds one more word, so the usable capacity is D+1 and every level threshold moves up by one.

Five active-low status outputs are produced from the registered pointers: an empty/output-ready flag, a full/input-ready flag, half-full, and two programmable flags. The almost-empty threshold n comes from `ae_ofs` and the almost-full margin m comes from `af_ofs`. Partial reset empties the buffer but keeps the captured mode. Retransmit rewinds the read side to location zero so that stored data can be read again. It has a normal variant, which passes through one recovery cycle, and a zero-latency variant, chosen at master reset.

The read side is a two-state machine. RUN is the working state. RECOVER lasts one cycle and follows a normal-latency retransmit. The transitions are: RUN to RECOVER when retransmit is sampled and normal latency is configured. RECOVER to RUN on the next edge with no retransmit. RECOVER to RECOVER when retransmit is sampled again. RUN to RUN otherwise, including on a zero-latency retransmit. Both resets force RUN.

Top module: `dual_mode_fifo`

## Requirements
- R1: While `mrst_n` is low at a clock edge, `cfg_fwft` (1 = fall-through, 0 = standard) and `cfg_zero_rt` (1 = zero-latency retransmit) are captured. They keep their values until the next master reset, whatever the pins do afterwards.
- R2: After an edge with `mrst_n` or `prst_n` low, the buffer is empty and `rd_data` is zero. The flags show empty: in standard mode `ef_or_n`=0, and in fall-through mode `ef_or_n`=1.
- R3: In standard mode, an edge with `rd_en_n` low and at least one stored word places the oldest word on `rd_data`. A read request while the buffer is empty is ignored, and `rd_data` holds its value.
- R4: In fall-through mode, a word written into an empty buffer at edge k is on `rd_data`, with `ef_or_n` low, after edge k+1, with no read request. Each later word needs `rd_en_n` low to advance.
- R5: A write (`wr_en_n` low) is accepted unless the count is D in standard mode or D+1 in fall-through mode. A write while full is ignored and never appears at the output.
- R6: Standard mode: `ef_or_n` is low exactly when the count is 0 (or during RECOVER), and `ff_ir_n` is low exactly when the count is D. Fall-through mode: `ef_or_n` is low exactly when the output register holds an unread word, and `ff_ir_n` is high exactly when the count is D+1.
- R7: `hf_n` is low exactly when the count is at least D/2+1 in standard mode, or at least D/2+2 in fall-through mode.
- R8: `pae_n` is high exactly when the count is at least n+1 in standard mode, or at least n+2 in fall-through mode, with n = `ae_ofs`.
- R9: `paf_n` is low exactly when the count is at least D−m in standard mode, or at least D−m+1 in fall-through mode, with m = `af_ofs`.
- R10: A read and a write on the same edge, with the buffer neither empty nor full, leave the count unchanged and keep data order.
- R11: With normal latency, `rt_n` low at an edge sets the read pointer to zero and leaves the write pointer alone. For the next cycle the state is RECOVER: standard mode shows `ef_or_n` low, fall-through mode shows `ef_or_n` high, and read requests are ignored. Reading then replays from the first word written since reset. This holds when at most D words have been written since reset.
- R12: With zero latency, `rt_n` low at an edge places the first word written since reset on `rd_data` at that same edge. Reading continues from the second word, and no empty/not-ready cycle is shown.
- R13: A partial reset does not change the captured mode or retransmit latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| mrst_n | input | 1 | Master reset, synchronous, active low |
| prst_n | input | 1 | Partial reset, synchronous, active low |
| cfg_fwft | input | 1 | Mode select, captured during master reset |
| cfg_zero_rt | input | 1 | Retransmit latency select, captured during master reset |
| ae_ofs | input | AW+1 | Almost-empty threshold n |
| af_ofs | input | AW+1 | Almost-full margin m |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | W | Write word |
| rd_en_n | input | 1 | Read request, active low |
| rt_n | input | 1 | Retransmit request, active low |
| rd_data | output | W | Output register |
| ef_or_n | output | 1 | Empty (standard) or output-ready (fall-through) |
| ff_ir_n | output | 1 | Full (standard) or input-ready (fall-through) |
| hf_n | output | 1 | Half-full, active low |
| pae_n | output | 1 | Almost-empty, active low |
| paf_n | output | 1 | Almost-full, active low |

## Verification
The bench builds the block with AW=3 and W=8, so D=8 and the full capacity is reached in eight or nine writes. This size allows a sweep of every almost-empty threshold from 0 to 8, each with a different almost-full margin, in all four mode and latency combinations. Every fill and drain compares each flag at every count level against thresholds computed in the bench. The small depth also brings over-full writes, empty reads, mixed read/write traffic and both retransmit variants within a few cycles of each partial reset.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
    typedef enum logic {
        S_RUN     = 1'b0,
        S_RECOVER = 1'b1
    } rd_state_e;
endpackage

// File: rtl/dmf_mem.sv
module dmf_mem #(
    parameter int AW = 4,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int D = 1 << AW;

    logic [W-1:0] store [D];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dmf_flags.sv
module dmf_flags #(
    parameter int AW = 4
) (
    input  logic          fwft,
    input  logic          recover,
    input  logic          out_vld,
    input  logic [AW+1:0] level,
    input  logic [AW:0]   ae_ofs,
    input  logic [AW:0]   af_ofs,
    output logic          ef_or_n,
    output logic          ff_ir_n,
    output logic          hf_n,
    output logic          pae_n,
    output logic          paf_n
);
    localparam int D = 1 << AW;

    int lvl;
    int adj;

    always_comb begin
        lvl = int'(level);
        adj = fwft ? 1 : 0;
        if (fwft) begin
            ef_or_n = !out_vld;
            ff_ir_n = (lvl == D + 1);
        end else begin
            ef_or_n = (lvl != 0) && !recover;
            ff_ir_n = (lvl != D);
        end
        hf_n  = !(lvl >= D / 2 + 1 + adj);
        pae_n = (lvl >= int'(ae_ofs) + 1 + adj);
        paf_n = !(lvl >= D - int'(af_ofs) + adj);
    end
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
    import dmf_pkg::*;
#(
    parameter int AW = 4,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          cfg_fwft,
    input  logic          cfg_zero_rt,
    input  logic [AW:0]   ae_ofs,
    input  logic [AW:0]   af_ofs,
    input  logic          wr_en_n,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en_n,
    input  logic          rt_n,
    output logic [W-1:0]  rd_data,
    output logic          ef_or_n,
    output logic          ff_ir_n,
    output logic          hf_n,
    output logic          pae_n,
    output logic          paf_n
);
    localparam int D = 1 << AW;
    localparam logic [AW:0] CNT_FULL = (AW+1)'(D);
    localparam logic [AW:0] PTR_ONE  = (AW+1)'(1);

    rd_state_e     state, state_nx;
    logic          fwft_q, zlat_q;
    logic [AW:0]   wptr, rptr, mem_cnt;
    logic [W-1:0]  out_q, mem_rd;
    logic          out_vld;
    logic [AW+1:0] level;
    logic [AW-1:0] rd_addr;
    logic          rt_go, run, wr_acc, rd_std, rd_fw, ld_fw, rt_load, pop;

    assign mem_cnt = wptr - rptr;
    assign level   = {1'b0, mem_cnt} + {{(AW+1){1'b0}}, (out_vld & fwft_q)};

    // Read-side decode for the current state
    always_comb begin
        run     = (state == S_RUN);
        rt_go   = !rt_n;
        wr_acc  = !wr_en_n && (mem_cnt != CNT_FULL);
        rd_std  = !fwft_q && run && !rt_go && !rd_en_n && (mem_cnt != '0);
        rd_fw   = fwft_q && run && !rt_go && out_vld && !rd_en_n;
        ld_fw   = fwft_q && run && !rt_go && (mem_cnt != '0) && (!out_vld || !rd_en_n);
        rt_load = rt_go && zlat_q && (wptr != '0);
        pop     = rd_std || ld_fw;
        rd_addr = rt_go ? '0 : rptr[AW-1:0];
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_RUN:     if (rt_go && !zlat_q) state_nx = S_RECOVER;
            S_RECOVER: state_nx = (rt_go && !zlat_q) ? S_RECOVER : S_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) begin
            state <= S_RUN;
        end else begin
            state <= state_nx;
        end
    end

    // Pointers, output register and captured configuration
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            fwft_q  <= cfg_fwft;
            zlat_q  <= cfg_zero_rt;
            wptr    <= '0;
            rptr    <= '0;
            out_q   <= '0;
            out_vld <= 1'b0;
        end else if (!prst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            out_q   <= '0;
            out_vld <= 1'b0;
        end else begin
            if (wr_acc) begin
                wptr <= wptr + PTR_ONE;
            end
            if (rt_go) begin
                rptr    <= rt_load ? PTR_ONE : '0;
                out_vld <= fwft_q && rt_load;
                if (rt_load) begin
                    out_q <= mem_rd;
                end
            end else begin
                if (pop) begin
                    rptr  <= rptr + PTR_ONE;
                    out_q <= mem_rd;
                end
                if (ld_fw) begin
                    out_vld <= 1'b1;
                end else if (rd_fw) begin
                    out_vld <= 1'b0;
                end
            end
        end
    end

    dmf_mem #(.AW(AW), .W(W)) u_mem (
        .clk   (clk),
        .we    (wr_acc && mrst_n && prst_n),
        .waddr (wptr[AW-1:0]),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (mem_rd)
    );

    dmf_flags #(.AW(AW)) u_flags (
        .fwft    (fwft_q),
        .recover (state == S_RECOVER),
        .out_vld (out_vld),
        .level   (level),
        .ae_ofs  (ae_ofs),
        .af_ofs  (af_ofs),
        .ef_or_n (ef_or_n),
        .ff_ir_n (ff_ir_n),
        .hf_n    (hf_n),
        .pae_n   (pae_n),
        .paf_n   (paf_n)
    );

    assign rd_data = out_q;
endmodule

// File: rtl/dmf_checker.sv
module dmf_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         mrst_n,
    input logic         prst_n,
    input logic         fwft_q,
    input logic         zlat_q,
    input logic         rd_en_n,
    input logic         rt_n,
    input logic [W-1:0] rd_data,
    input logic         ef_or_n,
    input logic         ff_ir_n,
    input logic         hf_n
);
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(fwft_q) && $stable(zlat_q)); // R1

    AST_PRST_CLEARS: assert property (@(posedge clk) disable iff (!mrst_n)
        !prst_n |=> (rd_data == '0)); // R2

    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        !fwft_q && !ef_or_n && !rd_en_n && rt_n |=> $stable(rd_data)); // R3

    AST_STD_FULL_HOLDS: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        !fwft_q && !ff_ir_n && rd_en_n && rt_n |=> !ff_ir_n); // R5

    AST_FWFT_FULL_HOLDS: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        fwft_q && ff_ir_n && rd_en_n && rt_n |=> ff_ir_n); // R5

    AST_FULL_IS_HALF: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        !fwft_q && !ff_ir_n |-> !hf_n); // R7

    AST_RT_RECOVER: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        !zlat_q && !rt_n |=> (fwft_q ? ef_or_n : !ef_or_n)); // R11
endmodule

bind dual_mode_fifo dmf_checker #(.W(W)) u_chk (
    .clk     (clk),
    .mrst_n  (mrst_n),
    .prst_n  (prst_n),
    .fwft_q  (fwft_q),
    .zlat_q  (zlat_q),
    .rd_en_n (rd_en_n),
    .rt_n    (rt_n),
    .rd_data (rd_data),
    .ef_or_n (ef_or_n),
    .ff_ir_n (ff_ir_n),
    .hf_n    (hf_n)
);

// File: tb/dual_mode_fifo_tb_top.sv
module dual_mode_fifo_tb_top;
    localparam int AW = 3;
    localparam int W  = 8;
    localparam int D  = 1 << AW;

    logic          clk = 1'b0;
    logic          mrst_n = 1'b0;
    logic          prst_n = 1'b1;
    logic          cfg_fwft = 1'b0;
    logic          cfg_zero_rt = 1'b0;
    logic [AW:0]   ae_ofs = '0;
    logic [AW:0]   af_ofs = '0;
    logic          wr_en_n = 1'b1;
    logic [W-1:0]  wr_data = '0;
    logic          rd_en_n = 1'b1;
    logic          rt_n = 1'b1;
    logic [W-1:0]  rd_data;
    logic          ef_or_n, ff_ir_n, hf_n, pae_n, paf_n;

    int vecs = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench model
    int memc, outv, expo, rtxm, f, z, n, m, dseq;
    int q[$];
    int hist[$];

    always #5 clk = ~clk;

    dual_mode_fifo #(.AW(AW), .W(W)) dut_i (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .cfg_fwft(cfg_fwft),
        .cfg_zero_rt(cfg_zero_rt), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n), .rt_n(rt_n),
        .rd_data(rd_data), .ef_or_n(ef_or_n), .ff_ir_n(ff_ir_n), .hf_n(hf_n),
        .pae_n(pae_n), .paf_n(paf_n)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string dtag);
        int tc;
        tc = memc + (f != 0 ? outv : 0);
        chk(dtag, "rd_data", int'(rd_data), expo);
        chk("R6", "ef_or_n", int'(ef_or_n), f != 0 ? int'(outv == 0) : int'(tc != 0 && rtxm == 0));
        chk("R6", "ff_ir_n", int'(ff_ir_n), f != 0 ? int'(tc == D + 1) : int'(tc != D));
        chk("R7", "hf_n", int'(hf_n), int'(!(tc >= D / 2 + 1 + f)));
        chk("R8", "pae_n", int'(pae_n), int'(tc >= n + 1 + f));
        chk("R9", "paf_n", int'(paf_n), int'(!(tc >= D - m + f)));
    endtask

    task automatic clear_model();
        memc = 0; outv = 0; expo = 0; rtxm = 0;
        q.delete(); hist.delete();
    endtask

    task automatic step(input bit w, input bit r, input bit rt, input string dtag);
        bit wacc;
        wr_en_n = !w; wr_data = W'(dseq); rd_en_n = !r; rt_n = !rt;
        wacc = w && (memc < D);
        if (rt) begin
            q = hist;
            rtxm = (z == 0);
            if (z != 0 && hist.size() > 0) begin
                expo = q.pop_front();
                memc = hist.size() - 1;
                outv = f;
            end else begin
                memc = hist.size();
                outv = 0;
            end
        end else if (rtxm != 0) begin
            rtxm = 0;
        end else if (f == 0) begin
            if (r && memc > 0) begin
                expo = q.pop_front();
                memc--;
            end
        end else begin
            if (memc > 0 && (outv == 0 || r)) begin
                expo = q.pop_front();
                memc--;
                outv = 1;
            end else if (outv != 0 && r) begin
                outv = 0;
            end
        end
        if (wacc) begin
            q.push_back(dseq);
            hist.push_back(dseq);
            memc++;
        end
        dseq = (dseq + 1) % 256;
        @(negedge clk);
        wr_en_n = 1'b1; rd_en_n = 1'b1; rt_n = 1'b1;
        chk_all(dtag);
    endtask

    task automatic do_mreset(input int fm, input int zm);
        f = fm; z = zm;
        mrst_n = 1'b0; cfg_fwft = fm[0]; cfg_zero_rt = zm[0];
        @(negedge clk);
        mrst_n = 1'b1;
        cfg_fwft = !fm[0]; cfg_zero_rt = !zm[0];   // R1: pins change, mode must not
        clear_model();
        chk_all("R2");
    endtask

    task automatic do_preset();
        prst_n = 1'b0;
        @(negedge clk);
        prst_n = 1'b1;
        clear_model();
        chk_all("R13");
    endtask

    initial begin
        dseq = 1;
        n = 0; m = 0;
        @(negedge clk);
        for (int cfg = 0; cfg < 4; cfg++) begin
            do_mreset(cfg % 2, cfg / 2);
            step(0, 0, 0, "R1");
            for (int nn = 0; nn <= D; nn++) begin
                n = nn; m = (nn * 5 + 3) % (D + 1);
                ae_ofs = (AW+1)'(n); af_ofs = (AW+1)'(m);
                do_preset();
                // fill to capacity, checking flags at every level
                for (int k = 0; k < D + f; k++) step(1, 0, 0, f != 0 ? "R4" : "R5");
                step(1, 0, 0, "R5");   // write while full is dropped
                step(0, 0, 0, "R5");
                // drain, one read past empty
                for (int k = 0; k < D + f + 1; k++) step(0, 1, 0, f != 0 ? "R4" : "R3");
                step(0, 1, 0, "R3");
                // mixed traffic
                for (int k = 0; k < 3; k++) step(1, 0, 0, "R5");
                for (int k = 0; k < 4; k++) step(1, 1, 0, "R10");
                for (int k = 0; k < 5; k++) step(0, 1, 0, "R10");
                // retransmit
                do_preset();
                for (int k = 0; k < 5; k++) step(1, 0, 0, "R5");
                step(0, 0, 0, "R4");
                step(0, 1, 0, "R3");
                step(0, 1, 0, "R3");
                step(0, 0, 1, z != 0 ? "R12" : "R11");
                step(0, 1, 0, z != 0 ? "R12" : "R11");
                for (int k = 0; k < 7; k++) step(0, 1, 0, z != 0 ? "R12" : "R11");
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end
endmodule